// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a serial bus protocol engine and a byte-wide non-volatile array. During a write session the engine hands over a start address and then a stream of data bytes. The block stores them in a 16-slot page buffer. The page part of the address is frozen when the session opens. Only the 4-bit offset advances, and it wraps inside the page, so a long stream overwrites bytes loaded earlier. Nothing reaches the array while the session is open.

When the engine signals the end of the session, the block reports busy for a programmable hold time that stands in for the array's write time. It then writes the loaded slots, and only those, one per cycle. Busy drops on the cycle after the last write. While busy, the block turns away every load strobe, so the engine can withhold acknowledge.

A write-protect level is sampled with the first data byte; if it is high the whole session is refused. A session that carries only an address writes nothing and just updates the current-address register used by later reads.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy, mem_we and load_nack are 0 and cur_addr is 0.
- R2: While a session is open (between sess_start and sess_end), mem_we stays 0 whatever bytes are loaded.
- R3: The page bits (cur_addr and mem_addr bits above bit 3) are those of start_addr. The offset (bits 3:0) of the k-th accepted byte is (start offset + k) mod 16, so a session never writes outside its page.
- R4: When more than 16 bytes are loaded, a later byte that lands on an offset already used replaces the earlier one, and each offset is written at most once per commit.
- R5: A commit writes only the offsets loaded in that session, in ascending offset order, one byte per clock with mem_we high.
- R6: After sess_end of a session with at least one accepted byte, busy is high for exactly WRITE_TICKS + N cycles, where N is the number of distinct offsets loaded. The N writes fill the last N of those cycles, and busy falls on the cycle after the last write.
- R7: If wp_sample is 1 together with the first byte_stb of a session, load_nack is 1 for that byte and for every later byte of the session, and the session ends with no write and no busy.
- R8: wp_sample is ignored on every byte_stb other than the first of a session.
- R9: A session with no data bytes produces no write and no busy, and leaves cur_addr equal to its start_addr.
- R10: At sess_end, cur_addr becomes the page of start_addr joined with the offset one past the last accepted byte, wrapped within the page. A refused session leaves cur_addr at start_addr.
- R11: While busy, sess_start, byte_stb and sess_end have no effect; a byte_stb then sees load_nack = 1. A byte_stb with no open session also sees load_nack = 1.
- R12: sess_abort closes an open session with no write, no busy and no change to cur_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_start | input | 1 | Opens a write session at start_addr (accepted when idle) |
| start_addr | input | $clog2(MEM_BYTES) | Byte address given by the bus master |
| byte_stb | input | 1 | One data byte is present on byte_data |
| byte_data | input | 8 | Data byte to load |
| wp_sample | input | 1 | Write-protect level, honoured with the first data byte only |
| sess_end | input | 1 | Session stop; starts the commit |
| sess_abort | input | 1 | Drops the open session without writing |
| load_nack | output | 1 | Combinational: the present byte_stb is refused |
| busy | output | 1 | Internal write cycle in progress |
| cur_addr | output | $clog2(MEM_BYTES) | Current address for a following read |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | $clog2(MEM_BYTES) | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench starts sessions near the end of a page so that the offset wraps. If the block carried the wrap into the page bits, writes would land in the next page. A stream of 18 bytes checks that the two late bytes win over the two early ones; a buffer that kept the first byte or appended a slot would show stale data or 17 or more writes. It counts busy cycles exactly, to catch a commit that writes untouched slots or that drops busy a cycle early or late. It also checks that protection applies only on the first byte, that strobes arriving mid-commit leave the written data and cur_addr untouched, and that an aborted or address-only session writes nothing.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    localparam int PAGE_BYTES = 16;
    localparam int OFF_W      = $clog2(PAGE_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HOLD,
        ST_DRAIN
    } pgc_state_e;

    typedef logic [PAGE_BYTES-1:0] slot_mask_t;

    typedef struct packed {
        logic [7:0]       data;
        logic [OFF_W-1:0] idx;
    } head_t;

    // index of the lowest set bit; 0 when the mask is empty
    function automatic logic [OFF_W-1:0] lowest_slot(slot_mask_t m);
        logic [OFF_W-1:0] r;
        r = '0;
        for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
            if (m[i]) r = OFF_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/pgc_wr_timer.sv
module pgc_wr_timer #(
    parameter int TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q == CW'(TICKS - 1));

    // R6
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q < CW'(TICKS)));
endmodule

// File: rtl/pgc_page_buf.sv
module pgc_page_buf
    import pgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             put_i,
    input  logic [7:0]       byte_i,
    input  logic             retire_i,
    output slot_mask_t       mask_o,
    output logic [OFF_W-1:0] ptr_o,
    output head_t            head_o
);
    logic [OFF_W-1:0] ptr_q;
    logic [7:0]       slot_q [PAGE_BYTES];
    logic [OFF_W-1:0] head_idx;

    assign head_idx = lowest_slot(mask_o);

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic vld_q;
        always_ff @(posedge clk) begin
            if (rst)                                    slot_q[g] <= '0;
            else if (put_i && ptr_q == OFF_W'(g))       slot_q[g] <= byte_i;
        end
        always_ff @(posedge clk) begin
            if (rst || open_i)                          vld_q <= 1'b0;
            else if (put_i && ptr_q == OFF_W'(g))       vld_q <= 1'b1;
            else if (retire_i && head_idx == OFF_W'(g)) vld_q <= 1'b0;
        end
        assign mask_o[g] = vld_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (open_i) ptr_q <= off_i;
        else if (put_i)  ptr_q <= ptr_q + 1'b1;   // wraps inside the page
    end

    assign ptr_o       = ptr_q;
    assign head_o.idx  = head_idx;
    assign head_o.data = slot_q[head_idx];

    // R4
    put_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (put_i && !open_i) |=> (mask_o != '0));
    // R5
    retire_one_chk: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !open_i && !put_i && mask_o != '0)
            |=> ($countones(mask_o) == $countones($past(mask_o)) - 1));
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pgc_pkg::*;
#(
    parameter int MEM_BYTES   = 1024,
    parameter int WRITE_TICKS = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sess_start,
    input  logic [$clog2(MEM_BYTES)-1:0] start_addr,
    input  logic                         byte_stb,
    input  logic [7:0]                   byte_data,
    input  logic                         wp_sample,
    input  logic                         sess_end,
    input  logic                         sess_abort,
    output logic                         load_nack,
    output logic                         busy,
    output logic [$clog2(MEM_BYTES)-1:0] cur_addr,
    output logic                         mem_we,
    output logic [$clog2(MEM_BYTES)-1:0] mem_addr,
    output logic [7:0]                   mem_wdata
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = AW - OFF_W;

    pgc_state_e       state_q;
    logic [PW-1:0]    page_q;
    logic             first_q;
    logic             rej_q;
    logic [AW-1:0]    cur_q;

    slot_mask_t       mask;
    logic [OFF_W-1:0] ptr;
    head_t            head;
    logic             expired;

    logic in_load, accept, open_s, put_s, byte_ev;

    assign in_load = (state_q == ST_LOAD);
    assign byte_ev = in_load && byte_stb && !sess_end && !sess_abort;
    assign accept  = in_load && !rej_q && !(first_q && wp_sample);
    assign open_s  = (state_q == ST_IDLE) && sess_start;
    assign put_s   = byte_ev && accept;

    pgc_page_buf u_buf (
        .clk      (clk),
        .rst      (rst),
        .open_i   (open_s),
        .off_i    (start_addr[OFF_W-1:0]),
        .put_i    (put_s),
        .byte_i   (byte_data),
        .retire_i (state_q == ST_DRAIN),
        .mask_o   (mask),
        .ptr_o    (ptr),
        .head_o   (head)
    );

    pgc_wr_timer #(.TICKS(WRITE_TICKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (state_q == ST_HOLD),
        .expired_o (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            first_q <= 1'b0;
            rej_q   <= 1'b0;
            cur_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (sess_start) begin
                    state_q <= ST_LOAD;
                    page_q  <= start_addr[AW-1:OFF_W];
                    first_q <= 1'b1;
                    rej_q   <= 1'b0;
                end
                ST_LOAD: begin
                    if (sess_abort) begin
                        state_q <= ST_IDLE;
                    end else if (sess_end) begin
                        cur_q   <= {page_q, ptr};
                        state_q <= (mask != '0 && !rej_q) ? ST_HOLD : ST_IDLE;
                    end else if (byte_stb) begin
                        first_q <= 1'b0;
                        if (first_q && wp_sample) rej_q <= 1'b1;
                    end
                end
                ST_HOLD:  if (expired) state_q <= ST_DRAIN;
                ST_DRAIN: if ($countones(mask) <= 1) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign load_nack = byte_stb && !accept;
    assign busy      = (state_q == ST_HOLD) || (state_q == ST_DRAIN);
    assign cur_addr  = cur_q;
    assign mem_we    = (state_q == ST_DRAIN) && (mask != '0);
    assign mem_addr  = {page_q, head.idx};
    assign mem_wdata = head.data;

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(sess_end));
    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mem_we));
    // R11
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_addr));
    // R11
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && byte_stb) |-> load_nack);
endmodule

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 1024;
    localparam int TICKS      = 12;
    localparam int AW         = $clog2(MEM_BYTES);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sess_start = 1'b0, byte_stb = 1'b0, wp_sample = 1'b0;
    logic          sess_end = 1'b0, sess_abort = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    byte_data = '0;
    logic          load_nack, busy, mem_we;
    logic [AW-1:0] cur_addr, mem_addr;
    logic [7:0]    mem_wdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int            wr_n = 0;
    int            busy_n = 0;
    logic [AW-1:0] wr_addr_log [32];
    logic [7:0]    wr_data_log [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_commit_ctrl #(.MEM_BYTES(MEM_BYTES), .WRITE_TICKS(TICKS)) i_page_commit_ctrl (
        .clk(clk), .rst(rst), .sess_start(sess_start), .start_addr(start_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .wp_sample(wp_sample),
        .sess_end(sess_end), .sess_abort(sess_abort), .load_nack(load_nack),
        .busy(busy), .cur_addr(cur_addr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    // write-port and busy observer, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_n++;
            if (mem_we) begin
                if (wr_n < 32) begin
                    wr_addr_log[wr_n] = mem_addr;
                    wr_data_log[wr_n] = mem_wdata;
                end
                wr_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        wr_n   = 0;
        busy_n = 0;
    endtask

    task automatic open_sess(input logic [AW-1:0] a);
        @(negedge clk);
        start_addr = a; sess_start = 1'b1;
        @(negedge clk);
        sess_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic wp, output logic nack);
        byte_data = d; wp_sample = wp; byte_stb = 1'b1;
        #1 nack = load_nack;
        @(negedge clk);
        byte_stb = 1'b0; wp_sample = 1'b0;
    endtask

    task automatic close_sess();
        sess_end = 1'b1;
        @(negedge clk);
        sess_end = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
        chk(load_nack == 1'b0, "R1", "load_nack after reset", load_nack, 0);
        chk(cur_addr == '0, "R1", "cur_addr after reset", cur_addr, 0);
    endtask

    task automatic t_basic();
        logic nack;
        clear_logs();
        open_sess(10'h123);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'hA0 + 8'(k), 1'b0, nack);
            chk(nack == 1'b0, "R3", "byte accepted", nack, 0);
        end
        chk(wr_n == 0, "R2", "no write while session open", wr_n, 0);
        close_sess();
        wait_idle();
        chk(busy_n == TICKS + 3, "R6", "busy length basic", busy_n, TICKS + 3);
        chk(wr_n == 3, "R5", "write count basic", wr_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk(wr_addr_log[k] == 10'h123 + 10'(k), "R5", "write address order",
                wr_addr_log[k], 10'h123 + k);
            chk(wr_data_log[k] == 8'hA0 + 8'(k), "R5", "write data", wr_data_log[k], 8'hA0 + k);
        end
        chk(cur_addr == 10'h126, "R10", "cur_addr after commit", cur_addr, 10'h126);
    endtask

    task automatic t_wrap();
        logic nack;
        logic [7:0] exp_d [16];
        clear_logs();
        open_sess(10'h0FE);
        for (int k = 0; k < 5; k++) begin
            send_byte(8'h10 + 8'(k), 1'b0, nack);
            exp_d[(14 + k) % 16] = 8'h10 + 8'(k);
        end
        close_sess();
        wait_idle();
        chk(busy_n == TICKS + 5, "R6", "busy length wrap", busy_n, TICKS + 5);
        chk(wr_n == 5, "R3", "write count wrap", wr_n, 5);
        begin
            int offs [5] = '{0, 1, 2, 14, 15};
            for (int k = 0; k < 5; k++) begin
                chk(wr_addr_log[k] == {6'h0F, 4'(offs[k])}, "R3", "wrapped address stays in page",
                    wr_addr_log[k], {6'h0F, 4'(offs[k])});
                chk(wr_data_log[k] == exp_d[offs[k]], "R3", "wrapped data",
                    wr_data_log[k], exp_d[offs[k]]);
            end
        end
        chk(cur_addr == 10'h0F3, "R10", "cur_addr after wrap", cur_addr, 10'h0F3);
    endtask

    task automatic t_overwrite();
        logic nack;
        logic [7:0] exp_d [16];
        clear_logs();
        open_sess(10'h205);
        for (int k = 0; k < 18; k++) begin
            send_byte(8'h40 + 8'(k), 1'b0, nack);
            exp_d[(5 + k) % 16] = 8'h40 + 8'(k);
        end
        close_sess();
        wait_idle();
        chk(wr_n == 16, "R4", "each offset written once", wr_n, 16);
        chk(busy_n == TICKS + 16, "R6", "busy length full page", busy_n, TICKS + 16);
        for (int k = 0; k < 16; k++) begin
            chk(wr_addr_log[k] == {6'h20, 4'(k)}, "R4", "full page address",
                wr_addr_log[k], {6'h20, 4'(k)});
            chk(wr_data_log[k] == exp_d[k], "R4", "newest byte wins", wr_data_log[k], exp_d[k]);
        end
        chk(cur_addr == 10'h207, "R10", "cur_addr after overwrite", cur_addr, 10'h207);
    endtask

    task automatic t_protect_first();
        logic nack;
        clear_logs();
        open_sess(10'h300);
        send_byte(8'h55, 1'b1, nack);
        chk(nack == 1'b1, "R7", "first byte refused under protect", nack, 1);
        send_byte(8'h56, 1'b0, nack);
        chk(nack == 1'b1, "R7", "later byte of refused session", nack, 1);
        close_sess();
        repeat (TICKS + 4) @(negedge clk);
        chk(wr_n == 0, "R7", "no write when protected", wr_n, 0);
        chk(busy_n == 0, "R7", "no busy when protected", busy_n, 0);
        chk(cur_addr == 10'h300, "R10", "cur_addr after refused session", cur_addr, 10'h300);
    endtask

    task automatic t_protect_late();
        logic nack;
        clear_logs();
        open_sess(10'h310);
        send_byte(8'h61, 1'b0, nack);
        chk(nack == 1'b0, "R8", "first byte accepted", nack, 0);
        send_byte(8'h62, 1'b1, nack);
        chk(nack == 1'b0, "R8", "protect ignored on second byte", nack, 0);
        close_sess();
        wait_idle();
        chk(wr_n == 2, "R8", "both bytes written", wr_n, 2);
        chk(wr_data_log[1] == 8'h62 && wr_addr_log[1] == 10'h311, "R8", "second byte data",
            wr_data_log[1], 8'h62);
    endtask

    task automatic t_addr_only();
        clear_logs();
        open_sess(10'h3AB);
        close_sess();
        repeat (TICKS + 4) @(negedge clk);
        chk(wr_n == 0, "R9", "no write for address-only", wr_n, 0);
        chk(busy_n == 0, "R9", "no busy for address-only", busy_n, 0);
        chk(cur_addr == 10'h3AB, "R9", "cur_addr set by address-only", cur_addr, 10'h3AB);
    endtask

    task automatic t_busy_ignore();
        logic nack;
        clear_logs();
        open_sess(10'h040);
        send_byte(8'h71, 1'b0, nack);
        send_byte(8'h72, 1'b0, nack);
        close_sess();
        chk(busy == 1'b1, "R6", "busy right after stop", busy, 1);
        open_sess(10'h050);
        send_byte(8'h99, 1'b0, nack);
        chk(nack == 1'b1, "R11", "byte refused while busy", nack, 1);
        close_sess();
        wait_idle();
        chk(wr_n == 2, "R11", "strobes during busy add no write", wr_n, 2);
        chk(wr_addr_log[1] == 10'h041 && wr_data_log[1] == 8'h72, "R11",
            "committed data untouched", wr_data_log[1], 8'h72);
        chk(busy_n == TICKS + 2, "R11", "busy length not extended", busy_n, TICKS + 2);
        chk(cur_addr == 10'h042, "R11", "cur_addr not moved by busy strobes", cur_addr, 10'h042);
        send_byte(8'h11, 1'b0, nack);
        chk(nack == 1'b1, "R11", "byte with no open session", nack, 1);
        clear_logs();
        close_sess();
        repeat (4) @(negedge clk);
        chk(busy_n == 0 && wr_n == 0, "R11", "stray stop when idle", busy_n + wr_n, 0);
    endtask

    task automatic t_abort();
        logic nack;
        clear_logs();
        open_sess(10'h060);
        send_byte(8'h81, 1'b0, nack);
        send_byte(8'h82, 1'b0, nack);
        sess_abort = 1'b1;
        @(negedge clk);
        sess_abort = 1'b0;
        close_sess();
        repeat (TICKS + 4) @(negedge clk);
        chk(wr_n == 0, "R12", "abort writes nothing", wr_n, 0);
        chk(busy_n == 0, "R12", "abort raises no busy", busy_n, 0);
        chk(cur_addr == 10'h042, "R12", "abort keeps cur_addr", cur_addr, 10'h042);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_overwrite();
        t_protect_first();
        t_protect_late();
        t_addr_only();
        t_busy_ignore();
        t_abort();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule